// File: doc/BRIEF.md
# HDLC Frame Transmitter with CPU-Refilled Byte Queue

This block turns bytes written by a processor into a serial HDLC bit stream, one bit per clock. Bytes enter a 64-entry queue. A frame is opened only by a start command. While a frame is open, the block asks for more data with a one-cycle pool-ready pulse each time the queue holds 32 bytes or fewer. The processor can instead poll a level that shows whether a 32-byte pool is free. An end-of-message command marks the bytes already in the queue as the tail of the frame. Bytes written after that command belong to the next frame.

When the frame has drained, the block appends a CRC-16 frame check sequence and a closing flag. In external-check mode the processor supplies the two check bytes itself, and the frame is closed with the flag alone. If the queue runs dry before the end-of-message command, the block sends an abort and raises an underrun pulse. A software reset flushes the queue and aborts a frame that is being sent. Between frames the line carries continuous flags. When the next frame is already armed, the closing flag of one frame also serves as the opening flag of the next.

Top module: `hdlc_pool_tx`

## Requirements
- R1: After reset and with no frame armed, `tx_bit` repeats the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0). `fifo_level` is 0, `pool_free` is 1, and both interrupt outputs are low.
- R2: With `crc_ext` low, a frame is the queued data bytes, each sent least significant bit first. They are followed by the one's complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF), low byte first, and then a closing flag.
- R3: Inside the data and check fields, a 0 is inserted after every five consecutive 1s. A receiver that removes the inserted zeros recovers the bytes exactly, even for data made of 0xFF and 0x7E.
- R4: Queued bytes are not sent until `cmd_start` is pulsed. Until then the line carries only flags and `fifo_level` is unchanged.
- R5: While a frame is open and no end-of-message command has been given, `pool_irq` pulses for one cycle each time `fifo_level` falls to 32 or below. The pulse repeats after each refill above 32. `pool_free` is high exactly when `fifo_level` is at most 32.
- R6: If the queue is empty at a byte boundary of an open frame before `cmd_eom`, the block sends an abort (0x7F, seven 1s, without zero insertion), then flags. It pulses `underrun_irq`, and no complete frame is delivered.
- R7: `cmd_reset` empties the queue (`fifo_level` is 0 on the next cycle), discards any pending start and end-of-message commands, and turns a frame in progress into an abort.
- R8: With `crc_ext` high, no check sequence is generated. The frame is exactly the queued bytes, followed by the closing flag.
- R9: When the next frame is armed and has data queued by the time the closing flag ends, no extra flag is sent: a single flag separates the two frames.
- R10: Frame length is not checked. A one-byte frame in external mode is sent as-is. A start plus end-of-message with an empty queue in internal mode sends a frame made of the two check bytes 0x00 0x00.
- R11: A write while `fifo_level` is 64 is ignored, so the level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to queue |
| cmd_start | input | 1 | Pulse: arm a frame for transmission |
| cmd_eom | input | 1 | Pulse: bytes now queued end the open frame |
| cmd_reset | input | 1 | Pulse: flush the queue and abort the frame |
| crc_ext | input | 1 | 1: the processor supplies the check bytes |
| tx_bit | output | 1 | Serial line output |
| pool_free | output | 1 | Polling status: a 32-byte pool is free |
| pool_irq | output | 1 | One-cycle request for the next data block |
| underrun_irq | output | 1 | One-cycle pulse when a frame is aborted for lack of data |
| fifo_level | output | 7 | Bytes currently queued |

## Verification
The hardest state to reach from the ports is the hand-off between two frames. The next frame must be armed, and its bytes must be queued behind the tail of the current frame, while that current frame is still draining. The bench gets there in a fixed order: it queues frame one, then pulses start and end-of-message. Next it writes frame two's bytes and pulses start again before frame one finishes. Only after its bit-level receiver sees frame one close does it issue frame two's end-of-message. It then confirms that no idle flag lies between the two frames. The repeated pool request is reached by keeping more than 32 bytes queued and refilling at the moment the request arrives.

// File: rtl/hdlc_pool_tx.sv
module hdlc_pool_tx #(
  parameter int DEPTH = 64,
  parameter int POOL  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cmd_start,
  input  logic       cmd_eom,
  input  logic       cmd_reset,
  input  logic       crc_ext,
  output logic       tx_bit,
  output logic       pool_free,
  output logic       pool_irq,
  output logic       underrun_irq,
  output logic [6:0] fifo_level
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] FLAG  = 8'h7E;
  localparam logic [7:0] ABORT = 8'h7F;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_CRC1, S_CRC2, S_ABRT} st_t;

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, rem;
  logic          armed, eom_seen;
  st_t           st;
  logic [7:0]    sh;
  logic [2:0]    bcnt, ones;
  logic          stf;
  logic [15:0]   crc;
  logic          pool_q;

  wire [7:0] rd        = mem[rp];
  wire       empty     = (cnt == '0);
  wire       full      = (cnt == CW'(DEPTH));
  wire       stuff_now = (ones == 3'd5);
  wire       load      = !stuff_now && (bcnt == 3'd7);
  wire       in_frame  = (st == S_DATA) || (st == S_CRC1) || (st == S_CRC2);
  wire       kill      = cmd_reset && in_frame;
  wire       push      = wr_en && !full && !cmd_reset;

  assign tx_bit     = stuff_now ? 1'b0 : sh[0];
  assign pool_free  = (cnt <= CW'(POOL));
  assign fifo_level = 7'(cnt);

  logic [7:0] nb;
  logic       n_stf, pop, take, fin, und, upd;
  st_t        nst;

  always_comb begin
    nb = FLAG; n_stf = 1'b0; nst = S_IDLE;
    pop = 1'b0; take = 1'b0; fin = 1'b0; und = 1'b0; upd = 1'b0;
    if (!cmd_reset) begin
      unique case (st)
        S_IDLE: begin
          if (armed) begin
            if (eom_seen && rem == '0) begin
              take = 1'b1;
              if (crc_ext) fin = 1'b1;
              else begin nb = ~crc[7:0]; n_stf = 1'b1; nst = S_CRC1; end
            end else if (!empty) begin
              take = 1'b1; pop = 1'b1; upd = 1'b1;
              nb = rd; n_stf = 1'b1; nst = S_DATA;
            end
          end
        end
        S_DATA: begin
          if (eom_seen && rem == '0) begin
            if (crc_ext) fin = 1'b1;
            else begin nb = ~crc[7:0]; n_stf = 1'b1; nst = S_CRC1; end
          end else if (!empty) begin
            pop = 1'b1; upd = 1'b1; nb = rd; n_stf = 1'b1; nst = S_DATA;
          end else begin
            nb = ABORT; nst = S_ABRT; und = 1'b1; fin = 1'b1;
          end
        end
        S_CRC1: begin nb = ~crc[15:8]; n_stf = 1'b1; nst = S_CRC2; end
        S_CRC2: fin = 1'b1;
        default: nst = S_IDLE;
      endcase
    end
  end

  wire pop_en  = load && pop;
  wire eom_acc = cmd_eom && !eom_seen && (armed || st == S_DATA);

  always_ff @(posedge clk) if (push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; rem <= '0;
      armed <= 1'b0; eom_seen <= 1'b0; crc <= 16'hFFFF;
    end else if (cmd_reset) begin
      wp <= '0; rp <= '0; cnt <= '0; rem <= '0;
      armed <= 1'b0; eom_seen <= 1'b0; crc <= 16'hFFFF;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop_en) rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop_en);
      if (cmd_start) armed <= 1'b1;
      else if (load && take) armed <= 1'b0;
      if (load && fin) eom_seen <= 1'b0;
      else if (eom_acc) begin
        eom_seen <= 1'b1;
        rem <= cnt - CW'(pop_en);
      end else if (eom_seen && pop_en) rem <= rem - 1'b1;
      if (load && fin) crc <= 16'hFFFF;
      else if (pop_en && upd && !crc_ext) crc <= crc_next(crc, rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= FLAG; bcnt <= '0; ones <= '0; stf <= 1'b0; st <= S_IDLE;
    end else if (kill) begin
      sh <= ABORT; bcnt <= '0; ones <= '0; stf <= 1'b0; st <= S_ABRT;
    end else if (stuff_now) begin
      ones <= '0;
    end else begin
      ones <= (stf && sh[0]) ? ones + 1'b1 : 3'd0;
      if (load) begin
        sh <= nb; stf <= n_stf; st <= nst; bcnt <= '0;
      end else begin
        sh <= sh >> 1; bcnt <= bcnt + 1'b1;
      end
    end
  end

  wire pool_cond = (armed || st == S_DATA) && !eom_seen && pool_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_q <= 1'b0; pool_irq <= 1'b0; underrun_irq <= 1'b0;
    end else begin
      pool_q       <= pool_cond;
      pool_irq     <= pool_cond && !pool_q;
      underrun_irq <= load && und && !cmd_reset;
    end
  end

  logic [2:0] run1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run1 <= '0;
    else run1 <= tx_bit ? ((run1 == 3'd7) ? run1 : run1 + 1'b1) : 3'd0;
  end

  a_r3_zero_after_five: assert property (@(posedge clk) disable iff (!rst_n)
    (stf && run1 == 3'd5) |-> !tx_bit);
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (cnt == '0));
  a_r6_abort_state: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_irq |-> (st == S_ABRT && !eom_seen));
  a_r5_pool_level: assert property (@(posedge clk) disable iff (!rst_n)
    pool_irq |-> ($past(cnt) <= CW'(POOL)));
  a_r2_crc_order: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CRC1 && load && !cmd_reset) |=> (st == S_CRC2));

endmodule

// File: tb/hdlc_pool_tx_tb.sv
module hdlc_pool_tx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cmd_start = 1'b0, cmd_eom = 1'b0, cmd_reset = 1'b0, crc_ext = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic tx_bit, pool_free, pool_irq, underrun_irq;
  logic [6:0] fifo_level;

  always #5 clk = ~clk;

  hdlc_pool_tx u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cmd_start(cmd_start), .cmd_eom(cmd_eom), .cmd_reset(cmd_reset), .crc_ext(crc_ext),
    .tx_bit(tx_bit), .pool_free(pool_free), .pool_irq(pool_irq),
    .underrun_irq(underrun_irq), .fifo_level(fifo_level));

  int n_chk = 0, n_err = 0, cyc = 0;
  int frames = 0, aborts = 0, last_gap = 0, gap_cnt = 0, pool_cnt = 0, und_cnt = 0;
  int rx_len = 0;
  logic [7:0] rx_frame [0:255];
  logic [7:0] exp_b [0:255];
  int exp_len = 0;

  int ones = 0, nb = 0;
  logic bits [0:4095];

  always @(negedge clk) if (rst_n) begin
    if (pool_irq) pool_cnt++;
    if (underrun_irq) und_cnt++;
    if (tx_bit) begin
      if (nb < 4096) begin bits[nb] = 1'b1; nb++; end
      ones++;
      if (ones == 7) begin aborts++; nb = 0; end
    end else begin
      if (ones >= 7) nb = 0;
      else if (ones == 6) begin
        automatic int n = nb - 7;
        if (n > 0 && n % 8 == 0) begin
          for (int k = 0; k < n / 8; k++)
            for (int j = 0; j < 8; j++) rx_frame[k][j] = bits[k*8+j];
          rx_len = n / 8; frames++; last_gap = gap_cnt; gap_cnt = 0;
        end else if (n <= 0) gap_cnt++;
        nb = 0;
      end else if (ones != 5) begin
        if (nb < 4096) begin bits[nb] = 1'b0; nb++; end
      end
      ones = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, exp_b[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic add_fcs();
    logic [15:0] c = ref_crc(exp_len);
    exp_b[exp_len] = ~c[7:0]; exp_b[exp_len+1] = ~c[15:8];
    exp_len += 2;
  endtask

  task automatic put_exp(input int from, input int n);
    for (int i = from; i < from + n; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = exp_b[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmd_start = 1'b1;
    else if (which == 1) cmd_eom = 1'b1;
    else cmd_reset = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0; cmd_eom = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic wait_frames(input string tag, input int target);
    int t = 0;
    while (frames < target && t < 3000) begin @(negedge clk); t++; end
    chk({tag, " frame arrives"}, frames, target);
  endtask

  task automatic cmp_frame(input string tag);
    chk({tag, " length"}, rx_len, exp_len);
    for (int i = 0; i < exp_len && i < rx_len; i++) chk({tag, " byte"}, rx_frame[i], exp_b[i]);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); chk("R1 idle flag bit", tx_bit, (8'h7E >> (i % 8)) & 1);
    end
    chk("R1 level", fifo_level, 0);
    chk("R1 pool_free", pool_free, 1);
    chk("R1 irqs", pool_irq | underrun_irq, 0);
  endtask

  task automatic t_hold_then_send();
    int f0 = frames;
    for (int i = 0; i < 5; i++) exp_b[i] = 8'(8'hA0 + i);
    exp_len = 5;
    put_exp(0, 5);
    repeat (200) @(negedge clk);
    chk("R4 no frame without start", frames, f0);
    chk("R4 level held", fifo_level, 5);
    chk("R4 no abort", aborts, 0);
    pulse(0); pulse(1);
    add_fcs();
    wait_frames("R2", f0 + 1);
    cmp_frame("R2 crc frame");
  endtask

  task automatic t_stuff();
    int f0 = frames, a0 = aborts;
    logic [7:0] pat [0:5] = '{8'hFF, 8'hFF, 8'h7E, 8'hFF, 8'h3F, 8'hFC};
    for (int i = 0; i < 6; i++) exp_b[i] = pat[i];
    exp_len = 6;
    put_exp(0, 6); pulse(0); pulse(1);
    add_fcs();
    wait_frames("R3", f0 + 1);
    cmp_frame("R3 stuffed frame");
    chk("R3 no abort seen", aborts, a0);
  endtask

  task automatic t_pool();
    int f0 = frames, p0 = pool_cnt, t = 0;
    for (int i = 0; i < 60; i++) exp_b[i] = 8'(i * 7 + 3);
    exp_len = 60;
    put_exp(0, 40);
    chk("R5 pool_free low above 32", pool_free, 0);
    chk("R5 no request before start", pool_cnt, p0);
    pulse(0);
    while (!pool_irq && t < 2000) begin @(negedge clk); t++; end
    chk("R5 first request", pool_irq, 1);
    chk("R5 level at request", fifo_level, 32);
    chk("R5 pool_free at request", pool_free, 1);
    put_exp(40, 20);
    t = 0;
    @(negedge clk);
    while (!pool_irq && t < 2000) begin @(negedge clk); t++; end
    chk("R5 repeated request", pool_irq, 1);
    chk("R5 level at second request", fifo_level, 32);
    pulse(1);
    add_fcs();
    wait_frames("R5", f0 + 1);
    cmp_frame("R5 long frame");
    chk("R5 request count", pool_cnt - p0, 2);
  endtask

  task automatic t_underrun();
    int f0 = frames, a0 = aborts, u0 = und_cnt;
    for (int i = 0; i < 3; i++) exp_b[i] = 8'(8'h10 + i);
    put_exp(0, 3); pulse(0);
    repeat (120) @(negedge clk);
    chk("R6 underrun pulse", und_cnt - u0, 1);
    chk("R6 abort on line", aborts - a0, 1);
    chk("R6 no frame delivered", frames, f0);
    chk("R6 queue empty", fifo_level, 0);
  endtask

  task automatic t_ext();
    int f0 = frames;
    crc_ext = 1'b1;
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33; exp_b[3] = 8'hAA; exp_b[4] = 8'h55;
    exp_len = 5;
    put_exp(0, 5); pulse(0); pulse(1);
    wait_frames("R8", f0 + 1);
    cmp_frame("R8 external check frame");
    exp_b[0] = 8'h5A; exp_len = 1;
    put_exp(0, 1); pulse(0); pulse(1);
    wait_frames("R10", f0 + 2);
    cmp_frame("R10 one byte frame");
    crc_ext = 1'b0;
    exp_len = 0;
    pulse(0); pulse(1);
    add_fcs();
    wait_frames("R10", f0 + 3);
    cmp_frame("R10 empty frame");
  endtask

  task automatic t_shared();
    int f0 = frames;
    for (int i = 0; i < 6; i++) exp_b[i] = 8'(8'h40 + i);
    put_exp(0, 6); pulse(0); pulse(1);
    for (int i = 0; i < 5; i++) exp_b[i] = 8'(8'hC0 + i);
    exp_len = 5;
    put_exp(0, 5); pulse(0);
    wait_frames("R9 first", f0 + 1);
    pulse(1);
    add_fcs();
    wait_frames("R9 second", f0 + 2);
    cmp_frame("R9 second frame");
    chk("R9 single shared flag", last_gap, 0);
  endtask

  task automatic t_sreset();
    int f0 = frames, a0 = aborts, u0 = und_cnt;
    for (int i = 0; i < 50; i++) exp_b[i] = 8'(i);
    put_exp(0, 50); pulse(0);
    repeat (100) @(negedge clk);
    pulse(2);
    chk("R7 flushed", fifo_level, 0);
    repeat (60) @(negedge clk);
    chk("R7 abort on line", aborts - a0, 1);
    chk("R7 no frame", frames, f0);
    chk("R7 no underrun pulse", und_cnt, u0);
    put_exp(0, 3);
    repeat (150) @(negedge clk);
    chk("R7 start discarded", frames, f0);
    chk("R7 bytes stay queued", fifo_level, 3);
    pulse(2);
    chk("R7 idle flush", fifo_level, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 70; i++) exp_b[i] = 8'(i);
    put_exp(0, 70);
    chk("R11 level capped", fifo_level, 64);
    chk("R11 pool_free low", pool_free, 0);
    pulse(2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_idle();
    t_hold_then_send();
    t_stuff();
    t_pool();
    t_underrun();
    t_ext();
    t_shared();
    t_sreset();
    t_full();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule